// File: doc/BRIEF.md
# Daisy-Chain Converter Refresh Sequencer

This block sits on the host side of a chain of serial-input 12-bit converters that share one data line, one strobe line and one load line. Each converter forwards what it receives twelve strobes later, so the chain behaves as a single long shift register. Software or a neighbouring block fills an internal word table through a simple write port, one entry per converter. It then pulses `start_i`. The sequencer serialises all words, most significant bit first, beginning with the word for the converter farthest from the host. After that it drops the shared load line so that every converter updates its output at the same instant.

The strobe idles high. For each bit the sequencer drives the data line, waits a setup interval, pulls the strobe low for the low time, and releases it. The converters capture on that rising edge. The line then stays high for the high time, which also serves as the data hold margin. All four intervals are counts of the system clock, set by parameters. At the defaults with an 8 ns clock they give an 88 ns strobe low pulse and a 184 ns load pulse. The load pulse begins directly after the last bit's high interval. `done_o` pulses for one cycle in the cycle the load line returns high.

Top module: `dac_chain_seq`

## Requirements
- R1: Out of reset and whenever `busy_o` is low, `strobe_o` and `load_n_o` are high, `sdata_o` is low and `done_o` is low.
- R2: Table entry k holds the word for the converter k positions from the host (entry 0 is nearest). After the load pulse, a chain of N_DEV 12-bit shift registers clocked on strobe rising edges holds entry k in converter k. This implies that entry N_DEV-1 is sent first.
- R3: Each transfer gives exactly N_DEV*12 strobe rising edges, and each word is sent with bit 11 first and bit 0 last.
- R4: Every strobe low pulse lasts exactly LO_CYC clock cycles, and `sdata_o` does not change while the strobe is low.
- R5: Before each strobe falling edge, the strobe has been high with the current bit on `sdata_o` for exactly SU_CYC cycles on the first bit of a transfer. On every later bit this interval is HI_CYC+SU_CYC cycles, because it counts the previous bit's hold interval plus the new bit's setup.
- R6: `load_n_o` goes low only after the final rising edge of the transfer and stays low for exactly LD_CYC cycles. The strobe stays high meanwhile.
- R7: `done_o` is high for exactly one cycle, the first cycle in which `load_n_o` is high again. `busy_o` is low in the following cycle.
- R8: `start_i` is ignored while `busy_o` is high, so a transfer gives one load pulse and one done pulse however often start is pulsed during it.
- R9: `wr_en_i` writes `wr_word_i` into table entry `wr_idx_i`. A write to an index of N_DEV or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word table write enable |
| wr_idx_i | input | IDX_W | Word table entry index (0 = converter nearest the host) |
| wr_word_i | input | WORD_W | Word written to the table |
| start_i | input | 1 | Begin a chain refresh (ignored while busy) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse as the load pulse ends |
| sdata_o | output | 1 | Serial data to the first converter |
| strobe_o | output | 1 | Shared strobe, idles high, capture on rising edge |
| load_n_o | output | 1 | Shared load line, active low |

## Verification
The bench builds the sequencer with N_DEV=3 and setup, low, high and load counts of 2, 3, 2 and 4 cycles. The 3-device chain crosses two word boundaries, so the reverse word order and the reload of the shifter between words become visible. The short, unequal counts make an off-by-one in any single phase show up as a wrong pulse width or interval, and they keep each transfer under 300 cycles. This allows many random word sets alongside all-zero, all-one and distinct-pattern words, restarts during a transfer, and a write to an index beyond the chain.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_LOAD,
    ST_DONE
  } seq_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dac_word_store.sv
module dac_word_store #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] mem [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) mem[g] <= wr_word_i;
    end
  end

  assign rd_word_o = mem[rd_idx_i];
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  // phase lasts len_i cycles: counts len_i-1 down to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic              last_bit_o
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      pos_q <= '0;
    end else if (shift_i) begin
      sh_q  <= sh_q << 1;
      pos_q <= pos_q + BIT_W'(1);
    end
  end

  assign bit_o      = sh_q[WORD_W-1];
  assign last_bit_o = (pos_q == BIT_W'(WORD_W-1));
endmodule

// File: rtl/dac_chain_seq.sv
module dac_chain_seq
  import dac_chain_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 12,
  parameter int SU_CYC = 3,
  parameter int LO_CYC = 11,
  parameter int HI_CYC = 11,
  parameter int LD_CYC = 23,
  parameter int IDX_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sdata_o,
  output logic              strobe_o,
  output logic              load_n_o
);
  localparam int MAX_C = max_of4(SU_CYC, LO_CYC, HI_CYC, LD_CYC);
  localparam int CNT_W = $clog2(MAX_C + 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d, rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic             tmr_ld, tmr_last;
  logic [CNT_W-1:0] tmr_len;
  logic             sh_load, sh_shift, sh_clr, sh_last;
  logic             strobe_q, load_n_q, busy_q, done_q;

  dac_word_store #(.N_DEV(N_DEV), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_word_i,
    .rd_idx_i(rd_idx), .rd_word_o(rd_word)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_ld), .len_i(tmr_len), .last_o(tmr_last)
  );

  dac_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .shift_i(sh_shift), .clear_i(sh_clr),
    .word_i(rd_word), .bit_o(sdata_o), .last_bit_o(sh_last)
  );

  // farthest converter's word goes first, then walk toward the host
  assign rd_idx = (state_q == ST_IDLE) ? IDX_W'(N_DEV-1) : widx_q - IDX_W'(1);

  always_comb begin
    state_d  = state_q;
    widx_d   = widx_q;
    tmr_ld   = 1'b0;
    tmr_len  = CNT_W'(SU_CYC);
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETUP;
        tmr_ld  = 1'b1;
        sh_load = 1'b1;
        widx_d  = IDX_W'(N_DEV-1);
      end
      ST_SETUP: if (tmr_last) begin
        state_d = ST_LOW;
        tmr_ld  = 1'b1;
        tmr_len = CNT_W'(LO_CYC);
      end
      ST_LOW: if (tmr_last) begin
        state_d = ST_HIGH;
        tmr_ld  = 1'b1;
        tmr_len = CNT_W'(HI_CYC);
      end
      ST_HIGH: if (tmr_last) begin
        tmr_ld = 1'b1;
        if (!sh_last) begin
          state_d  = ST_SETUP;
          sh_shift = 1'b1;
        end else if (widx_q == '0) begin
          state_d = ST_LOAD;
          tmr_len = CNT_W'(LD_CYC);
          sh_clr  = 1'b1;
        end else begin
          state_d = ST_SETUP;
          sh_load = 1'b1;
          widx_d  = widx_q - IDX_W'(1);
        end
      end
      ST_LOAD: if (tmr_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // line outputs registered from next state: glitch-free, aligned with state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      strobe_q <= 1'b1;
      load_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      widx_q   <= widx_d;
      strobe_q <= (state_d != ST_LOW);
      load_n_q <= (state_d != ST_LOAD);
      busy_q   <= (state_d != ST_IDLE);
      done_q   <= (state_d == ST_DONE);
    end
  end

  assign strobe_o = strobe_q;
  assign load_n_o = load_n_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dac_chain_seq_chk.sv
module dac_chain_seq_chk #(
  parameter int LO_CYC = 11,
  parameter int LD_CYC = 23
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic sdata_o,
  input logic strobe_o,
  input logic load_n_o
);
  logic        seen_q;
  logic [15:0] lo_cnt_q, ld_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      lo_cnt_q <= '0;
      ld_cnt_q <= '0;
    end else begin
      seen_q   <= 1'b1;
      lo_cnt_q <= strobe_o ? 16'd0 : lo_cnt_q + 16'd1;
      ld_cnt_q <= load_n_o ? 16'd0 : ld_cnt_q + 16'd1;
    end
  end

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (strobe_o && load_n_o && !done_o)); // R1

  AST_STROBE_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && lo_cnt_q != 16'd0) |-> (lo_cnt_q == 16'(LO_CYC))); // R4

  AST_DATA_STABLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !strobe_o && !$past(strobe_o)) |-> $stable(sdata_o)); // R4

  AST_LOAD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_o && ld_cnt_q != 16'd0) |-> (ld_cnt_q == 16'(LD_CYC))); // R6

  AST_NO_STROBE_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_n_o |-> (strobe_o && busy_o)); // R6

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(load_n_o)) |-> done_o); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R7
endmodule

bind dac_chain_seq dac_chain_seq_chk #(.LO_CYC(LO_CYC), .LD_CYC(LD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .sdata_o(sdata_o), .strobe_o(strobe_o), .load_n_o(load_n_o)
);

// File: tb/dac_chain_seq_test.sv
module dac_chain_seq_test;
  localparam int B_N  = 3;
  localparam int B_W  = 12;
  localparam int B_SU = 2;
  localparam int B_LO = 3;
  localparam int B_HI = 2;
  localparam int B_LD = 4;
  localparam int B_IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [B_IW-1:0] wr_idx = '0;
  logic [B_W-1:0]  wr_word = '0;
  logic start = 1'b0;
  logic busy, done, sdata, strobe, load_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [B_W-1:0] exp_w [B_N];
  logic [B_W-1:0] chain [B_N];
  int  rises = 0, dones = 0, low_run = 0, high_run = 0, load_run = 0;
  bit  first_bit = 1'b1, after_done = 1'b0;
  logic prev_strobe = 1'b1, prev_load = 1'b1, prev_sdata = 1'b0;

  always #4 clk = ~clk;

  dac_chain_seq #(.N_DEV(B_N), .WORD_W(B_W), .SU_CYC(B_SU), .LO_CYC(B_LO),
                  .HI_CYC(B_HI), .LD_CYC(B_LD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_word_i(wr_word), .start_i(start), .busy_o(busy), .done_o(done),
    .sdata_o(sdata), .strobe_o(strobe), .load_n_o(load_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_high_run(input bit first);
    return first ? B_SU : (B_HI + B_SU);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R7 watchdog expired, done not seen actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // chain model and line timing monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_strobe = 1'b1; prev_load = 1'b1; prev_sdata = 1'b0;
      low_run = 0; high_run = 0; load_run = 0;
    end else begin
      if (after_done) begin
        chk(!done, "R7 done width", done, 0);
        chk(!busy, "R7 busy after done", busy, 0);
        after_done = 1'b0;
      end
      if (!busy) begin
        chk(strobe && load_n && !sdata && !done, "R1 idle lines",
            {strobe, load_n, sdata, done}, 4'b1100);
        high_run = 0;
      end
      if (!strobe && !prev_strobe)
        chk(sdata == prev_sdata, "R4 data stable while low", sdata, prev_sdata);
      if (!strobe && prev_strobe) begin
        chk(high_run == exp_high_run(first_bit), "R5 setup interval",
            high_run, exp_high_run(first_bit));
        first_bit = 1'b0;
        high_run = 0;
      end
      if (strobe && !prev_strobe) begin
        chk(low_run == B_LO, "R4 strobe low width", low_run, B_LO);
        for (int k = B_N - 1; k > 0; k--) chain[k] = {chain[k][B_W-2:0], chain[k-1][B_W-1]};
        chain[0] = {chain[0][B_W-2:0], sdata};
        rises++;
        low_run = 0;
      end
      if (!strobe) low_run++;
      else if (busy && load_n) high_run++;
      if (!load_n && prev_load) begin
        chk(rises == B_N * B_W, "R3 R6 rising edges before load", rises, B_N * B_W);
        for (int k = 0; k < B_N; k++)
          chk(chain[k] == exp_w[k], "R2 R3 converter word", chain[k], exp_w[k]);
      end
      if (!load_n) begin
        chk(strobe, "R6 strobe high during load", strobe, 1);
        load_run++;
      end
      if (load_n && !prev_load) begin
        chk(load_run == B_LD, "R6 load width", load_run, B_LD);
        chk(done, "R7 done as load ends", done, 1);
        load_run = 0;
        after_done = 1'b1;
      end
      if (done) dones++;
      prev_strobe = strobe; prev_load = load_n; prev_sdata = sdata;
    end
  end

  task automatic write_word(input int idx, input logic [B_W-1:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = B_IW'(idx); wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < B_N) exp_w[idx] = w;
  endtask

  task automatic run_xfer(input bit restart);
    int d0;
    @(posedge clk);
    rises = 0; first_bit = 1'b1;
    d0 = dones;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart) begin
      repeat (17) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    while (dones == d0) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(dones == d0 + 1, "R8 one done per transfer", dones - d0, 1);
    chk(!busy, "R8 idle after transfer", busy, 0);
  endtask

  initial begin
    void'($urandom(32'h0c0ffee5));
    for (int k = 0; k < B_N; k++) begin exp_w[k] = '0; chain[k] = '0; end
    repeat (3) @(negedge clk);
    chk(strobe && load_n && !busy && !done && !sdata, "R1 reset state",
        {strobe, load_n, busy, done, sdata}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_xfer(1'b0);                                  // all zero table, R2
    for (int k = 0; k < B_N; k++) write_word(k, 12'hfff);
    run_xfer(1'b0);                                  // all ones, R3
    write_word(0, 12'h001); write_word(1, 12'h800); write_word(2, 12'ha5c);
    run_xfer(1'b0);                                  // distinct words expose order, R2
    write_word(3, 12'h3c3);                          // beyond chain, R9
    run_xfer(1'b0);
    write_word(1, 12'h7e1);                          // overwrite one entry, R9
    run_xfer(1'b1);                                  // restarts while busy, R8
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < B_N; k++) write_word(k, B_W'($urandom() % 4096));
      if ($urandom() % 3 == 0) write_word(3, B_W'($urandom() % 4096));
      repeat ($urandom() % 5) @(negedge clk);
      run_xfer(t == 5);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule